// File: doc/BRIEF.md
# Page Table Descriptor Checker

This stage sits inside a hardware table-search engine. Each time the engine fetches a 32-bit descriptor word from memory it presents the word here, together with the table level it came from (an upper table or the page level), the kind of access being translated (read or write, supervisor or user) and the page-size setting. One cycle later the stage reports what the engine must do next. The choices are to stop with a fault, to descend into the next table, to follow an indirect pointer to another page descriptor, or to finish with a physical frame. It also reports the address that goes with that action and the attributes of the page.

The stage keeps a little state across one walk. A `walk_first` strobe marks the first descriptor of a new walk. Write protection seen at upper levels is OR-accumulated and applied to the final page. At most one indirect hop is allowed per walk. When a descriptor's used bit, or a written page's modified bit, must be set, the stage raises a write-back request and supplies the updated descriptor word. Memory sequencing is left to the surrounding engine.

Top module: `pdesc_check`

## Requirements
- R1: At an upper level (`lvl_page`=0), a type field `desc_in[1:0]` of 00 or 01 gives action fault (code 0) with fault kind invalid (code 1). A type of 10 or 11 gives action descend (code 1) with `next_addr` = `desc_in[31:9]` followed by nine zero bits.
- R2: At the page level (`lvl_page`=1), type 00 gives fault/invalid and types 01 or 11 give action done (code 3). Type 10 gives action indirect (code 2) with `next_addr` = `desc_in[31:2]` followed by two zero bits.
- R3: For a done page, `next_addr` = `desc_in[31:13]` followed by 13 zero bits. `cache_mode` = `desc_in[6:5]`, `user_attr` = `desc_in[9:8]` unchanged, and `global_pg` = `desc_in[10]`.
- R4: `rsv_bits[0]` = `desc_in[11]`. `rsv_bits[1]` = `desc_in[12]` when `page_8k`=0 (4 KB pages) and 0 when `page_8k`=1.
- R5: `desc_in[2]` is write protect. `wp_eff` is the OR of that bit on every upper-level descriptor since `walk_first` and on the current descriptor. A write (`acc_write`=1) to a resident page with `wp_eff`=1 faults with kind protection (code 2), and a read does not.
- R6: A resident page with `desc_in[7]`=1 (supervisor only) faults with kind protection when `acc_super`=0.
- R7: A non-faulting descriptor with used bit `desc_in[3]`=0 raises `wb_req`, and `wb_word` is the descriptor with bit 3 set.
- R8: A write to a done page whose modified bit `desc_in[4]` is 0 raises `wb_req`, and `wb_word` has bit 4 set as well as bit 3. A read never sets bit 4.
- R9: Any fault gives `wb_req`=0, and a non-fault action gives fault kind none (code 0).
- R10: A second indirect page descriptor within one walk gives fault with kind hop limit (code 3).
- R11: Results appear one clock after `in_valid` with `out_valid`=1. `out_valid` is 0 after reset and whenever `in_valid` was 0, and the result outputs hold their values until the next valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| walk_first | input | 1 | Descriptor is the first of a new walk |
| desc_in | input | 32 | Fetched descriptor word |
| lvl_page | input | 1 | 1 = page level, 0 = upper table level |
| acc_write | input | 1 | Access being translated is a write |
| acc_super | input | 1 | Access is made in supervisor mode |
| page_8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB pages |
| out_valid | output | 1 | Result valid |
| action | output | 2 | 0 fault, 1 descend, 2 indirect, 3 done |
| fault_kind | output | 2 | 0 none, 1 invalid, 2 protection, 3 hop limit |
| next_addr | output | 32 | Next table, indirect target or frame address |
| wb_req | output | 1 | Descriptor write-back needed |
| wb_word | output | 32 | Descriptor with used/modified bits set |
| cache_mode | output | 2 | Page cache mode |
| user_attr | output | 2 | Page user attribute bits |
| global_pg | output | 1 | Page global bit |
| rsv_bits | output | 2 | User-reserved bits |
| wp_eff | output | 1 | Accumulated write protection |

## Verification
Directed cases cover all four type codes at both levels. They separate the upper-level rule, where 01 is invalid, from the page-level rule, where 01 is resident and 10 is indirect. Two-hop walks with protection only on the upper descriptor, tried with reads and then writes, show whether protection is carried down and is cleared by a new walk. Separate cases cover used/modified combinations under reads and writes, supervisor-only pages with both privilege levels, and a double indirect chain. Random walks of one to four descriptors with random words and access types then compare every output against a bench model.

// File: rtl/pdesc_pkg.sv
package pdesc_pkg;
  typedef enum logic [1:0] {
    ACT_FAULT    = 2'd0,
    ACT_DESCEND  = 2'd1,
    ACT_INDIRECT = 2'd2,
    ACT_DONE     = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2,
    FLT_HOPS    = 2'd3
  } flt_e;

  localparam int unsigned BIT_WP    = 2;
  localparam int unsigned BIT_USED  = 3;
  localparam int unsigned BIT_MOD   = 4;
  localparam int unsigned BIT_SUPER = 7;
  localparam int unsigned BIT_GLOB  = 10;
  localparam int unsigned BIT_RSV0  = 11;
  localparam int unsigned BIT_RSV1  = 12;
endpackage

// File: rtl/pdesc_decode.sv
module pdesc_decode
  import pdesc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned TBL_LSB = 9,
  parameter int unsigned PG_LSB  = 13,
  parameter int unsigned IND_LSB = 2
) (
  input  logic [DW-1:0] desc,
  input  logic          is_page,
  input  logic          is_write,
  input  logic          is_super,
  input  logic          wp_base,
  input  logic          ind_base,
  output act_e          act,
  output flt_e          flt,
  output logic [DW-1:0] addr,
  output logic          wb_req,
  output logic [DW-1:0] wb_word,
  output logic          wp_cur,
  output logic          wp_next,
  output logic          ind_next
);
  logic up_res, pg_inv, pg_ind, pg_res, prot, set_u, set_m;

  always_comb begin
    up_res = desc[1];
    pg_inv = (desc[1:0] == 2'b00);
    pg_ind = (desc[1:0] == 2'b10);
    pg_res = desc[0];
    wp_cur = wp_base | desc[BIT_WP];
    prot   = (is_write & wp_cur) | (desc[BIT_SUPER] & ~is_super);

    act      = ACT_FAULT;
    flt      = FLT_NONE;
    addr     = '0;
    wp_next  = wp_base;
    ind_next = ind_base;

    if (!is_page) begin
      wp_next = wp_cur;
      if (up_res) begin
        act  = ACT_DESCEND;
        addr = {desc[DW-1:TBL_LSB], {TBL_LSB{1'b0}}};
      end else begin
        flt = FLT_INVALID;
      end
    end else if (pg_inv) begin
      flt = FLT_INVALID;
    end else if (pg_ind) begin
      ind_next = 1'b1;
      if (ind_base) begin
        flt = FLT_HOPS;
      end else begin
        act  = ACT_INDIRECT;
        addr = {desc[DW-1:IND_LSB], {IND_LSB{1'b0}}};
      end
    end else if (pg_res && prot) begin
      flt = FLT_PROT;
    end else begin
      act  = ACT_DONE;
      addr = {desc[DW-1:PG_LSB], {PG_LSB{1'b0}}};
    end

    set_u   = ~desc[BIT_USED];
    set_m   = (act == ACT_DONE) & is_write & ~desc[BIT_MOD];
    wb_req  = (act != ACT_FAULT) & (set_u | set_m);
    wb_word = desc;
    wb_word[BIT_USED] = 1'b1;
    if (set_m) wb_word[BIT_MOD] = 1'b1;
  end
endmodule

// File: rtl/pdesc_walk_state.sv
module pdesc_walk_state (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  logic wp_next,
  input  logic ind_next,
  output logic wp_base,
  output logic ind_base
);
  logic wp_q, ind_q;

  always_comb begin
    wp_base  = first ? 1'b0 : wp_q;
    ind_base = first ? 1'b0 : ind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      ind_q <= 1'b0;
    end else if (en) begin
      wp_q  <= wp_next;
      ind_q <= ind_next;
    end
  end
endmodule

// File: rtl/pdesc_check.sv
module pdesc_check
  import pdesc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned TBL_LSB = 9,
  parameter int unsigned PG_LSB  = 13,
  parameter int unsigned IND_LSB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          walk_first,
  input  logic [DW-1:0] desc_in,
  input  logic          lvl_page,
  input  logic          acc_write,
  input  logic          acc_super,
  input  logic          page_8k,
  output logic          out_valid,
  output logic [1:0]    action,
  output logic [1:0]    fault_kind,
  output logic [DW-1:0] next_addr,
  output logic          wb_req,
  output logic [DW-1:0] wb_word,
  output logic [1:0]    cache_mode,
  output logic [1:0]    user_attr,
  output logic          global_pg,
  output logic [1:0]    rsv_bits,
  output logic          wp_eff
);
  act_e          d_act;
  flt_e          d_flt;
  logic [DW-1:0] d_addr, d_wbw;
  logic          d_wb, d_wp, wp_nx, ind_nx, wp_b, ind_b;
  logic [1:0]    d_rsv;

  pdesc_walk_state u_state (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .first(walk_first),
    .wp_next(wp_nx), .ind_next(ind_nx), .wp_base(wp_b), .ind_base(ind_b)
  );

  pdesc_decode #(.DW(DW), .TBL_LSB(TBL_LSB), .PG_LSB(PG_LSB), .IND_LSB(IND_LSB)) u_dec (
    .desc(desc_in), .is_page(lvl_page), .is_write(acc_write), .is_super(acc_super),
    .wp_base(wp_b), .ind_base(ind_b), .act(d_act), .flt(d_flt), .addr(d_addr),
    .wb_req(d_wb), .wb_word(d_wbw), .wp_cur(d_wp), .wp_next(wp_nx), .ind_next(ind_nx)
  );

  always_comb begin
    d_rsv = {page_8k ? 1'b0 : desc_in[BIT_RSV1], desc_in[BIT_RSV0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      action     <= 2'd0;
      fault_kind <= 2'd0;
      next_addr  <= '0;
      wb_req     <= 1'b0;
      wb_word    <= '0;
      cache_mode <= 2'd0;
      user_attr  <= 2'd0;
      global_pg  <= 1'b0;
      rsv_bits   <= 2'd0;
      wp_eff     <= 1'b0;
    end else if (in_valid) begin
      action     <= d_act;
      fault_kind <= d_flt;
      next_addr  <= d_addr;
      wb_req     <= d_wb;
      wb_word    <= d_wbw;
      cache_mode <= desc_in[6:5];
      user_attr  <= desc_in[9:8];
      global_pg  <= desc_in[BIT_GLOB];
      rsv_bits   <= d_rsv;
      wp_eff     <= d_wp;
    end
  end
endmodule

// File: rtl/pdesc_check_sva.sv
module pdesc_check_sva #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [1:0]    action,
  input logic [1:0]    fault_kind,
  input logic [DW-1:0] next_addr,
  input logic          wb_req,
  input logic [DW-1:0] wb_word
);
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && action == 2'd0) |-> !wb_req); // R9
  AST_KIND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && action != 2'd0) |-> fault_kind == 2'd0); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(action) && $stable(next_addr))); // R11
  AST_WB_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wb_req) |-> wb_word[3]); // R7
  AST_DESCEND_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && action == 2'd1) |-> next_addr[8:0] == 9'd0); // R1
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && action == 2'd3) |-> next_addr[12:0] == 13'd0); // R3
endmodule

bind pdesc_check pdesc_check_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .action(action), .fault_kind(fault_kind), .next_addr(next_addr),
  .wb_req(wb_req), .wb_word(wb_word)
);

// File: tb/pdesc_check_bench.sv
`timescale 1ns/1ps
module pdesc_check_bench;
  logic        clk, rst_n, in_valid, walk_first, lvl_page, acc_write, acc_super, page_8k;
  logic [31:0] desc_in;
  logic        out_valid, wb_req, global_pg, wp_eff;
  logic [1:0]  action, fault_kind, cache_mode, user_attr, rsv_bits;
  logic [31:0] next_addr, wb_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit m_wp, m_ind;

  pdesc_check u_pdesc_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .walk_first(walk_first),
    .desc_in(desc_in), .lvl_page(lvl_page), .acc_write(acc_write),
    .acc_super(acc_super), .page_8k(page_8k), .out_valid(out_valid),
    .action(action), .fault_kind(fault_kind), .next_addr(next_addr),
    .wb_req(wb_req), .wb_word(wb_word), .cache_mode(cache_mode),
    .user_attr(user_attr), .global_pg(global_pg), .rsv_bits(rsv_bits), .wp_eff(wp_eff)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run one descriptor through the DUT and compare with the model.
  task automatic step(input bit first, input bit pg, input logic [31:0] d,
                      input bit wr, input bit sup, input bit big);
    logic [1:0] e_act, e_flt, e_rsv;
    logic [31:0] e_addr, e_wbw;
    bit e_wb, wpc, prot, set_u, set_m, bw, bi;
    bw = first ? 1'b0 : m_wp;
    bi = first ? 1'b0 : m_ind;
    wpc = bw | d[2];
    prot = (wr & wpc) | (d[7] & ~sup);
    e_act = 2'd0; e_flt = 2'd0; e_addr = 32'd0;
    if (!pg) begin
      m_wp = wpc; m_ind = bi;
      if (d[1]) begin e_act = 2'd1; e_addr = {d[31:9], 9'd0}; end
      else e_flt = 2'd1;
    end else begin
      m_wp = bw;
      m_ind = bi | (d[1:0] == 2'b10);
      if (d[1:0] == 2'b00) e_flt = 2'd1;
      else if (d[1:0] == 2'b10) begin
        if (bi) e_flt = 2'd3;
        else begin e_act = 2'd2; e_addr = {d[31:2], 2'd0}; end
      end else if (prot) e_flt = 2'd2;
      else begin e_act = 2'd3; e_addr = {d[31:13], 13'd0}; end
    end
    set_u = ~d[3];
    set_m = (e_act == 2'd3) & wr & ~d[4];
    e_wb = (e_act != 2'd0) & (set_u | set_m);
    e_wbw = d | 32'h8 | (set_m ? 32'h10 : 32'h0);
    e_rsv = {big ? 1'b0 : d[12], d[11]};

    @(negedge clk);
    in_valid = 1'b1; walk_first = first; lvl_page = pg; desc_in = d;
    acc_write = wr; acc_super = sup; page_8k = big;
    @(negedge clk);
    in_valid = 1'b0; desc_in = $urandom; walk_first = $urandom;
    chk(out_valid === 1'b1, "R11 out_valid", {31'd0, out_valid}, 32'd1);
    chk(action === e_act, pg ? "R2 action" : "R1 action", {30'd0, action}, {30'd0, e_act});
    chk(fault_kind === e_flt, "R5 R6 R10 fault_kind", {30'd0, fault_kind}, {30'd0, e_flt});
    chk(next_addr === e_addr, "R3 next_addr", next_addr, e_addr);
    chk(wb_req === e_wb, "R7 R8 R9 wb_req", {31'd0, wb_req}, {31'd0, e_wb});
    if (e_wb) chk(wb_word === e_wbw, "R7 R8 wb_word", wb_word, e_wbw);
    chk(wp_eff === wpc, "R5 wp_eff", {31'd0, wp_eff}, {31'd0, wpc});
    chk(rsv_bits === e_rsv, "R4 rsv_bits", {30'd0, rsv_bits}, {30'd0, e_rsv});
    chk(cache_mode === d[6:5] && user_attr === d[9:8] && global_pg === d[10],
        "R3 attributes", {21'd0, global_pg, user_attr, cache_mode, 5'd0}, {21'd0, d[10], d[9:8], d[6:5], 5'd0});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] hold_act;
    logic [31:0] hold_addr;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; in_valid = 0; walk_first = 0; lvl_page = 0; desc_in = 0;
    acc_write = 0; acc_super = 0; page_8k = 0;
    m_wp = 0; m_ind = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && wb_req === 1'b0, "R11 reset state", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: upper level type codes
    step(1, 0, 32'hABCD_E000, 0, 1, 0);
    step(1, 0, 32'hABCD_E001, 0, 1, 0);
    step(1, 0, 32'hABCD_E3FA, 0, 1, 0);
    step(1, 0, 32'hABCD_E00B, 0, 1, 0);
    // R2: page level type codes
    step(1, 1, 32'h1234_5000, 0, 1, 0);
    step(1, 1, 32'h1234_5001, 0, 1, 0);
    step(1, 1, 32'h1234_567E, 0, 1, 0);
    step(1, 1, 32'h1234_5FFB, 0, 1, 0);
    // R4: reserved bits under both page sizes
    step(1, 1, 32'h0000_1809, 0, 1, 0);
    step(1, 1, 32'h0000_1809, 0, 1, 1);
    // R5: protection on upper path, read then write, then new walk clears it
    step(1, 0, 32'h0000_0206, 0, 0, 0);
    step(0, 1, 32'h0000_2019, 0, 1, 0);
    step(1, 0, 32'h0000_0206, 1, 0, 0);
    step(0, 1, 32'h0000_2019, 1, 1, 0);
    step(1, 0, 32'h0000_020A, 1, 0, 0);
    step(0, 1, 32'h0000_2009, 1, 1, 0);
    // R6: supervisor-only page
    step(1, 1, 32'h0000_4089, 0, 0, 0);
    step(1, 1, 32'h0000_4089, 0, 1, 0);
    // R7/R8: used and modified combinations
    step(1, 1, 32'h0000_6001, 1, 1, 0);
    step(1, 1, 32'h0000_6009, 1, 1, 0);
    step(1, 1, 32'h0000_6011, 1, 1, 0);
    step(1, 1, 32'h0000_6001, 0, 1, 0);
    step(1, 1, 32'h0000_6019, 1, 1, 0);
    // R10: double indirect
    step(1, 1, 32'h0000_8002, 0, 1, 0);
    step(0, 1, 32'h0000_9002, 0, 1, 0);
    // R11: outputs hold while idle
    hold_act = action; hold_addr = next_addr;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle valid", {31'd0, out_valid}, 32'd0);
    chk(action === hold_act && next_addr === hold_addr, "R11 hold", next_addr, hold_addr);

    // Random walks
    for (int w = 0; w < 400; w++) begin
      int len;
      len = 1 + ($urandom % 4);
      for (int s = 0; s < len; s++) begin
        step(s == 0, (s == len - 1) ? 1'b1 : ($urandom % 3 == 0), $urandom,
             $urandom % 2, $urandom % 2, $urandom % 2);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule